// File: doc/BRIEF.md
# Calendar RTC register interface

A memory-mapped real-time-clock register block with a 32-bit, word-only bus. It keeps a packed calendar date, a packed time of day with weekday, a control/status word and a set of scratch registers. A one-pulse-per-second tick advances the seconds, and carries ripple through minutes, hours, day of month, weekday, month and year. The year is held as an offset from a base year. The leap-year rule uses the full year: the day count of February depends on whether the base year plus the offset is a multiple of four.

Software sets the clock by writing the date or time word. Each such write raises a pending bit in the control/status word. A read of that word returns the pending bits and clears them in the same access. A parameter selects one of two register layouts. The layout fixes the offsets, the number of scratch registers and the base year. After reset the date and time hold preload values given as parameters, and everything else is zero.

Top module: `rtc_calendar_regs`

## Requirements
- R1: After reset the control word and every scratch register read 0, the date reads PRE_DATE and the time reads PRE_TIME.
- R2: A write to the date word sets control bit 7 and a write to the time word sets control bit 8. All other control bits read 0, and bus writes to the control word have no effect.
- R3: A read of the control word returns its current value, and bits 7 and 8 read 0 from the next cycle on.
- R4: The date word holds the day of month in bits 7:0, the month (1..12) in bits 15:8 and the year offset in bits 31:16. The time word holds the second in bits 5:0, the minute in bits 13:8, the hour in bits 20:16 and the weekday in bits 31:29 (0 = Monday .. 6 = Sunday). A written value reads back unchanged until the next tick.
- R5: On each tick the second increments. Second 59 wraps to 0 and increments the minute, minute 59 wraps to 0 and increments the hour, and hour 23 wraps to 0.
- R6: When the hour wraps, the weekday increments (6 wraps to 0) and the date advances by one day.
- R7: The day wraps to 1 after 30 in April, June, September and November, after 31 in the other months, and after February 28 or 29, with 29 when the base year plus the offset is divisible by 4. Month 12 wraps to 1 and increments the year offset. The base year is 2010 for layout 0 and 1970 for layout 1.
- R8: A write to the time word in a tick cycle stores the written value, and that tick has no effect on time or date. A write to the date word in a tick cycle stores the written value, while the time still advances.
- R9: Any access whose byte enables are not all ones, whose address is not a multiple of 4, or whose address hits no register reads 0, and a write of that kind changes no register. When the bus is idle or writing, the read data is 0.
- R10: Layout 0 places control at 0x000, date at 0x004, time at 0x008 and 4 scratch words at 0x020..0x02C. Layout 1 places control at 0x000, date at 0x010, time at 0x014 and 8 scratch words at 0x100..0x11C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per elapsed second |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |

## Verification
A bus write to the date or time word and a tick can arrive in the same cycle. So can a control read and the tick that follows a date write. The bench drives a time write together with a tick, and then a date write together with a tick that crosses midnight. A behavioural model settles each conflict by the R8 priorities, and the bench compares both layouts' read data against that model on every clock. The model also tracks pending bits across ticks, so a flag set beside a tick and then cleared by a read is judged cycle by cycle.

// File: rtl/rtc_calendar_regs.sv
module rtc_calendar_regs #(
  parameter int          LAYOUT   = 0,
  parameter int          AW       = 12,
  parameter logic [31:0] PRE_DATE = 32'h000E_021C,
  parameter logic [31:0] PRE_TIME = 32'h6017_3B32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1hz,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [3:0]    bus_be,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata
);

  localparam int            BASE_YEAR = (LAYOUT == 0) ? 2010 : 1970;
  localparam int            NUM_GP    = (LAYOUT == 0) ? 4 : 8;
  localparam int            GPW       = $clog2(NUM_GP);
  localparam logic [AW-1:0] OFF_DATE  = AW'((LAYOUT == 0) ? 'h004 : 'h010);
  localparam logic [AW-1:0] OFF_TIME  = AW'((LAYOUT == 0) ? 'h008 : 'h014);
  localparam logic [AW-1:0] OFF_GP    = AW'((LAYOUT == 0) ? 'h020 : 'h100);
  localparam logic [1:0]    BASE_MOD4 = 2'(BASE_YEAR % 4);

  logic [31:0] date_q, time_q;
  logic        pend_date, pend_time;
  logic [31:0] gp_q [NUM_GP];

  // decode
  logic [AW-1:0] gp_off;
  assign gp_off = bus_addr - OFF_GP;

  wire word_ok  = (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);
  wire hit_ctrl = word_ok && (bus_addr == '0);
  wire hit_date = word_ok && (bus_addr == OFF_DATE);
  wire hit_time = word_ok && (bus_addr == OFF_TIME);
  wire hit_gp   = word_ok && (bus_addr >= OFF_GP) &&
                  (gp_off[AW-1:GPW+2] == '0) && (gp_off[1:0] == 2'b00);
  wire [GPW-1:0] gp_idx = gp_off[GPW+1:2];

  wire wr       = bus_sel & bus_we;
  wire rd       = bus_sel & ~bus_we;
  wire wr_date  = wr & hit_date;
  wire wr_time  = wr & hit_time;
  wire rd_ctrl  = rd & hit_ctrl;

  wire [31:0] ctrl_val = (32'(pend_time) << 8) | (32'(pend_date) << 7);

  // time of day
  wire [5:0] sec  = time_q[5:0];
  wire [5:0] mnt  = time_q[13:8];
  wire [4:0] hr   = time_q[20:16];
  wire [2:0] wday = time_q[31:29];

  wire sec_wrap  = sec >= 6'd59;
  wire min_wrap  = sec_wrap && (mnt >= 6'd59);
  wire day_carry = min_wrap && (hr >= 5'd23);

  logic [31:0] time_nx;
  always_comb begin
    time_nx       = time_q;
    time_nx[5:0]  = sec_wrap ? 6'd0 : sec + 6'd1;
    if (sec_wrap)  time_nx[13:8]  = min_wrap ? 6'd0 : mnt + 6'd1;
    if (min_wrap)  time_nx[20:16] = day_carry ? 5'd0 : hr + 5'd1;
    if (day_carry) time_nx[31:29] = (wday >= 3'd6) ? 3'd0 : wday + 3'd1;
  end

  // calendar
  wire [7:0] day  = date_q[7:0];
  wire [7:0] mon  = date_q[15:8];
  wire       leap = (BASE_MOD4 + date_q[17:16]) == 2'd0;

  logic [7:0] dim;
  always_comb begin
    case (mon)
      8'd2:                      dim = leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   dim = 8'd30;
      default:                   dim = 8'd31;
    endcase
  end

  wire day_wrap = day >= dim;
  wire mon_wrap = day_wrap && (mon >= 8'd12);

  logic [31:0] date_nx;
  always_comb begin
    date_nx       = date_q;
    date_nx[7:0]  = day_wrap ? 8'd1 : day + 8'd1;
    if (day_wrap) date_nx[15:8]  = mon_wrap ? 8'd1 : mon + 8'd1;
    if (mon_wrap) date_nx[31:16] = date_q[31:16] + 16'd1;
  end

  // state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= PRE_TIME;
      date_q <= PRE_DATE;
    end else begin
      if (wr_time)       time_q <= bus_wdata;
      else if (tick_1hz) time_q <= time_nx;

      if (wr_date)                              date_q <= bus_wdata;
      else if (tick_1hz && !wr_time && day_carry) date_q <= date_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_date <= 1'b0;
      pend_time <= 1'b0;
    end else begin
      if (wr_date)      pend_date <= 1'b1;
      else if (rd_ctrl) pend_date <= 1'b0;
      if (wr_time)      pend_time <= 1'b1;
      else if (rd_ctrl) pend_time <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_GP; i++) gp_q[i] <= '0;
    end else if (wr && hit_gp) begin
      gp_q[gp_idx] <= bus_wdata;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (hit_ctrl)      bus_rdata = ctrl_val;
      else if (hit_date) bus_rdata = date_q;
      else if (hit_time) bus_rdata = time_q;
      else if (hit_gp)   bus_rdata = gp_q[gp_idx];
    end
  end

  // checks
  p_date_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_date |=> pend_date);

  p_time_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_time |=> pend_time);

  p_ctrl_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |=> (!pend_date && !pend_time));

  p_sec_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !wr_time && (time_q[5:0] < 6'd59)) |=>
      (time_q[5:0] == $past(time_q[5:0]) + 6'd1));

  p_midnight_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !wr_time && day_carry) |=>
      (time_q[20:16] == 5'd0 && time_q[13:8] == 6'd0));

  p_time_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_time |=> (time_q == $past(bus_wdata)));

  p_bad_access_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && (bus_be != 4'hF || bus_addr[1:0] != 2'b00)) |-> (bus_rdata == '0));

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> (bus_rdata == '0));

endmodule

// File: tb/test_rtc_calendar_regs.sv
module test_rtc_calendar_regs;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] PRE_D = 32'h000E_021C;
  localparam logic [31:0] PRE_T = 32'h6017_3B32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1hz = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_be = 4'h0;
  logic [11:0] addr_a = '0, addr_b = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_a, rdata_b;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar_regs #(.LAYOUT(0), .AW(12), .PRE_DATE(PRE_D), .PRE_TIME(PRE_T)) i_rtc_calendar_regs (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_be(bus_be), .bus_addr(addr_a), .bus_wdata(bus_wdata), .bus_rdata(rdata_a));

  rtc_calendar_regs #(.LAYOUT(1), .AW(12), .PRE_DATE(PRE_D), .PRE_TIME(PRE_T)) i_rtc_calendar_regs_b (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_be(bus_be), .bus_addr(addr_b), .bus_wdata(bus_wdata), .bus_rdata(rdata_b));

  // reference model, index 0 = layout 0, 1 = layout 1
  logic [31:0] m_date [2];
  logic [31:0] m_time [2];
  logic [31:0] m_gp   [2][8];
  logic        m_pd   [2];
  logic        m_pt   [2];

  function automatic int reg_addr(int k, int id);
    if (id == 0) return 0;
    if (id == 1) return (k == 1) ? 'h010 : 'h004;
    if (id == 2) return (k == 1) ? 'h014 : 'h008;
    return ((k == 1) ? 'h100 : 'h020) + 4 * (id - 3);
  endfunction

  function automatic int decode(int k, logic [3:0] be, logic [11:0] a);
    int ngp = (k == 1) ? 8 : 4;
    if (be != 4'hF || a[1:0] != 2'b00) return -1;
    for (int id = 0; id < 3 + ngp; id++)
      if (int'(a) == reg_addr(k, id)) return id;
    return -1;
  endfunction

  function automatic int days_in(int mo, int full_year);
    if (mo == 2) return (full_year % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] expect_rd(int k, logic sel, logic we, logic [3:0] be, logic [11:0] a);
    int id;
    if (!sel || we) return '0;
    id = decode(k, be, a);
    if (id < 0)  return '0;
    if (id == 0) return (32'(m_pt[k]) << 8) | (32'(m_pd[k]) << 7);
    if (id == 1) return m_date[k];
    if (id == 2) return m_time[k];
    return m_gp[k][id-3];
  endfunction

  task automatic model_clock(int k, logic sel, logic we, logic [3:0] be, logic [11:0] a,
                             logic [31:0] wd, logic tk);
    int id = decode(k, be, a);
    logic wt = sel && we && id == 2;
    logic wdt = sel && we && id == 1;
    int se, mi, hr, wdy, dy, mo, yr;
    logic carry = 1'b0;
    logic [31:0] t = m_time[k];
    logic [31:0] d = m_date[k];
    if (tk && !wt) begin
      se = int'(t[5:0]); mi = int'(t[13:8]); hr = int'(t[20:16]); wdy = int'(t[31:29]);
      if (se == 59) begin
        se = 0;
        if (mi == 59) begin
          mi = 0;
          if (hr == 23) begin
            hr = 0; carry = 1'b1;
            wdy = (wdy == 6) ? 0 : wdy + 1;
          end else hr++;
        end else mi++;
      end else se++;
      t[5:0] = 6'(se); t[13:8] = 6'(mi); t[20:16] = 5'(hr); t[31:29] = 3'(wdy);
      m_time[k] = t;
      if (carry && !wdt) begin
        dy = int'(d[7:0]); mo = int'(d[15:8]); yr = int'(d[31:16]);
        if (dy == days_in(mo, ((k == 1) ? 1970 : 2010) + yr)) begin
          dy = 1;
          if (mo == 12) begin mo = 1; yr++; end else mo++;
        end else dy++;
        d[7:0] = 8'(dy); d[15:8] = 8'(mo); d[31:16] = 16'(yr);
        m_date[k] = d;
      end
    end
    if (sel && !we && id == 0) begin m_pd[k] = 1'b0; m_pt[k] = 1'b0; end
    if (sel && we) begin
      if (id == 1) begin m_date[k] = wd; m_pd[k] = 1'b1; end
      else if (id == 2) begin m_time[k] = wd; m_pt[k] = 1'b1; end
      else if (id >= 3) m_gp[k][id-3] = wd;
    end
  endtask

  // one bus cycle; both layouts compared every clock
  task automatic cyc(logic sel, logic we, logic [3:0] be, int id, logic [11:0] raw,
                     logic [31:0] wd, logic tk, string tag);
    logic [31:0] exp_v, got;
    @(negedge clk);
    bus_sel = sel; bus_we = we; bus_be = be; bus_wdata = wd; tick_1hz = tk;
    addr_a = (id >= 0) ? 12'(reg_addr(0, id)) : raw;
    addr_b = (id >= 0) ? 12'(reg_addr(1, id)) : raw;
    #1;
    for (int k = 0; k < 2; k++) begin
      exp_v = expect_rd(k, sel, we, be, (k == 1) ? addr_b : addr_a);
      got = (k == 1) ? rdata_b : rdata_a;
      checks++;
      if (got !== exp_v) begin
        errors++;
        $display("FAIL %s layout %0d: got %h expected %h", tag, k, got, exp_v);
      end
    end
    @(posedge clk);
    model_clock(0, sel, we, be, addr_a, wd, tk);
    model_clock(1, sel, we, be, addr_b, wd, tk);
  endtask

  task automatic rd(int id, string tag);
    cyc(1'b1, 1'b0, 4'hF, id, '0, '0, 1'b0, tag);
  endtask

  task automatic wr(int id, logic [31:0] v, string tag);
    cyc(1'b1, 1'b1, 4'hF, id, '0, v, 1'b0, tag);
  endtask

  task automatic midnight(logic [31:0] d, string tag);
    wr(1, d, tag);
    wr(2, 32'h4017_3B3B, tag);
    cyc(1'b1, 1'b0, 4'hF, 2, '0, '0, 1'b1, tag);
    rd(1, tag);
    rd(2, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      m_date[k] = PRE_D; m_time[k] = PRE_T; m_pd[k] = 1'b0; m_pt[k] = 1'b0;
      for (int i = 0; i < 8; i++) m_gp[k][i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int id = 0; id < 11; id++) rd(id, "R1 reset");

    // R5 ticks from 23:59:50 across midnight, R6 R7 leap February
    for (int i = 0; i < 12; i++) cyc(1'b1, 1'b0, 4'hF, 2, '0, '0, 1'b1, "R5 tick");
    rd(1, "R7 leap day");
    rd(2, "R6 weekday");

    // R2 R3 R4 pending flags and readback
    wr(2, 32'hC017_3B3B, "R4 time write");
    rd(2, "R4 time readback");
    rd(0, "R2 time flag");
    rd(0, "R3 flag cleared");
    wr(1, 32'h0001_021C, "R4 date write");
    rd(1, "R4 date readback");
    cyc(1'b1, 1'b0, 4'hF, 2, '0, '0, 1'b1, "R6 weekday wrap");
    rd(1, "R7 february non-leap");
    rd(2, "R6 weekday 6 to 0");
    rd(0, "R2 date flag");
    rd(0, "R3 cleared again");

    // R7 month and year rollover
    midnight(32'h0005_0C1F, "R7 year wrap");
    midnight(32'h0003_041E, "R7 april");
    midnight(32'h0003_011F, "R7 january");
    midnight(32'h0002_021D, "R7 leap feb29");
    midnight(32'h0002_021C, "R7 leap feb28");
    midnight(32'h0003_0B1E, "R7 november");

    // R8 write priority over tick
    cyc(1'b1, 1'b1, 4'hF, 2, '0, 32'h0000_0005, 1'b1, "R8 time write with tick");
    rd(2, "R8 time kept");
    rd(1, "R8 date untouched");
    wr(2, 32'h2017_3B3B, "R8 setup");
    cyc(1'b1, 1'b1, 4'hF, 1, '0, 32'h0007_0914, 1'b1, "R8 date write with tick");
    rd(1, "R8 date kept");
    rd(2, "R8 time advanced");
    rd(0, "R3 both flags");
    rd(0, "R3 both cleared");

    // R10 scratch registers in both layouts
    for (int i = 0; i < 8; i++) wr(3 + i, 32'hA500_0000 + 32'(i * 17), "R10 scratch write");
    for (int i = 0; i < 8; i++) rd(3 + i, "R10 scratch read");

    // R9 ignored accesses
    cyc(1'b1, 1'b1, 4'h3, 3, '0, 32'h1234_5678, 1'b0, "R9 partial write");
    rd(3, "R9 scratch unchanged");
    cyc(1'b1, 1'b0, 4'h1, 2, '0, '0, 1'b0, "R9 partial read");
    cyc(1'b1, 1'b0, 4'hF, -1, 12'h021, '0, 1'b0, "R9 unaligned read");
    cyc(1'b1, 1'b1, 4'hF, -1, 12'h00C, 32'hFFFF_FFFF, 1'b0, "R9 unassigned write");
    cyc(1'b1, 1'b0, 4'hF, -1, 12'h00C, '0, 1'b0, "R9 unassigned read");
    cyc(1'b1, 1'b1, 4'hF, -1, 12'h3F0, 32'hFFFF_FFFF, 1'b0, "R9 outside write");
    cyc(1'b1, 1'b0, 4'hF, -1, 12'h3F0, '0, 1'b0, "R9 outside read");
    for (int id = 0; id < 11; id++) rd(id, "R9 state after ignored writes");
    wr(0, 32'hFFFF_FFFF, "R2 control write");
    rd(0, "R2 control write ignored");
    cyc(1'b1, 1'b1, 4'hF, 2, '0, 32'h0, 1'b0, "R9 idle write data");
    cyc(1'b0, 1'b0, 4'hF, 2, '0, '0, 1'b0, "R9 idle bus");

    // R5 long run with sparse ticks
    wr(2, 32'h0016_3A00, "R5 setup");
    for (int i = 0; i < 400; i++)
      cyc(1'b1, 1'b0, 4'hF, (i % 3 == 0) ? 2 : 1, '0, '0, (i % 2 == 0), "R5 run");
    rd(0, "R3 after run");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule